// File: doc/BRIEF.md
# Opcode-Addressed Register Slave over Mode 0 SPI

This block is a serial peripheral slave running in SPI Mode 0. It samples SCK, CSN and SI in the system clock domain. Over that link it gives a host access to a small set of configuration registers and to a read-only 32-bit status word. Every transaction sits inside one chip-select frame and starts with an 8-bit opcode. Bit 7 of the opcode selects the direction. The rest of the opcode selects the target, and with it the fixed number of data bytes that follow.

The configuration registers are:
- a control register holding a self-test enable and a soft reset;
- a 4-bit per-bank sensor type;
- a 4-bit self-test pattern;
- two 6+6-bit threshold settings, one for ground/open banks and one for supply/open banks.

The status word comes in on `status_i`. It is read out either as one 8-bit bank or as all four banks in a single transfer. Each configuration register also drives an output port, so the neighbouring sense logic can use it.

Top module: `spi_opreg_slave`

## Requirements
- R1: After rst_ni is released, every configuration output is 0 and so_oe_o is 0.
- R2: Write opcodes take one data byte and update the register on the last SCK rising edge of that byte. Opcode 0x02 writes the control register (bit0 = test enable, bit1 = soft reset). Opcode 0x04 writes the bank type from data[3:0]. Opcode 0x1E writes the test pattern from data[3:0]. Upper bits are dropped.
- R3: Opcodes 0x3A (ground/open) and 0x3C (supply/open) take two data bytes. The first byte's bits [5:0] set the hysteresis and the second byte's bits [5:0] set the center value.
- R4: Read opcodes 0x82, 0x84, 0x9E, 0xBA and 0xBC return the register written by the same opcode with bit 7 cleared. Data is sent MSB first, and for 0xBA/0xBC the hysteresis byte comes first. The first data bit is driven on the SCK falling edge right after the last opcode bit.
- R5: Read opcodes 0x90, 0x92, 0x94 and 0x96 each return one status byte. Opcode 0x90 + 2*n returns status_i[8n+7:8n].
- R6: Opcode 0xF8 returns four bytes, status_i[31:24] first. All four bytes come from one snapshot of status_i taken when the opcode byte completes.
- R7: A byte cut short by CSN rising is discarded, and the next frame starts a fresh opcode.
- R8: Each frame carries one instruction. Bytes beyond the opcode's count neither write anything nor drive SO.
- R9: While control bit1 is 1, every other register, including test enable, reads and drives 0, and writes to them are ignored. Writing control with bit1 = 0 releases the hold.
- R10: A reserved write opcode changes no register. A reserved read opcode returns one byte of 0x00.
- R11: so_oe_o is 0 during the opcode byte, after the last data bit of a read, and whenever CSN is high.
- R12: SI data clocked during a read has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, idles low |
| csn_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| status_i | input | 32 | Live status word, one byte per bank |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | SO drive enable; 0 means high impedance |
| soft_rst_o | output | 1 | Soft reset bit of the control register |
| test_en_o | output | 1 | Self-test enable bit |
| bank_type_o | output | 4 | Sensor type per bank |
| test_pat_o | output | 4 | Self-test pattern |
| gnd_hys_o | output | 6 | Ground/open hysteresis code |
| gnd_ctr_o | output | 6 | Ground/open center code |
| sup_hys_o | output | 6 | Supply/open hysteresis code |
| sup_ctr_o | output | 6 | Supply/open center code |

## Verification
The assertions assume SCK high and low phases each last longer than the synchronizer depth plus one clock. They also assume CSN changes only while SCK is low, so that every serial edge is seen as exactly one rise or fall. The bench holds each SCK phase for eight system clocks. It moves SI and CSN only on the falling side of SCK, and it switches status_i only between bits, so the stimulus stays inside those limits.

// File: rtl/spi_opreg_pkg.sv
package spi_opreg_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_BANKS = 4;
  localparam int IDX_W   = 3;
  localparam int NB_W    = 3;

  typedef enum logic [3:0] {
    T_NONE, T_CTRL, T_BANK, T_GTH, T_STH, T_TPAT, T_STAT, T_ALL
  } tgt_e;

  typedef struct packed {
    logic            rd;
    tgt_e            tgt;
    logic [1:0]      sel;
    logic [NB_W-1:0] nbytes;
  } op_t;

  function automatic op_t op_decode(input logic [BYTE_W-1:0] b);
    op_t o;
    o.rd     = b[7];
    o.tgt    = T_NONE;
    o.sel    = b[2:1];
    o.nbytes = b[7] ? NB_W'(1) : NB_W'(0);
    case (b[6:0])
      7'h02: begin o.tgt = T_CTRL; o.nbytes = NB_W'(1); end
      7'h04: begin o.tgt = T_BANK; o.nbytes = NB_W'(1); end
      7'h1E: begin o.tgt = T_TPAT; o.nbytes = NB_W'(1); end
      7'h3A: begin o.tgt = T_GTH;  o.nbytes = NB_W'(2); end
      7'h3C: begin o.tgt = T_STH;  o.nbytes = NB_W'(2); end
      7'h10, 7'h12, 7'h14, 7'h16: if (b[7]) o.tgt = T_STAT;
      7'h78: if (b[7]) begin o.tgt = T_ALL; o.nbytes = NB_W'(N_BANKS); end
      default: ;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/spi_opreg_sync.sv
module spi_opreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic si_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_act_o,
  output logic si_o
);
  logic [STAGES-1:0] sck_q, csn_q, si_q;
  logic              sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= '0;
      csn_q <= '1;
      si_q  <= '0;
      sck_d <= 1'b0;
    end else begin
      sck_q <= {sck_q[STAGES-2:0], sck_i};
      csn_q <= {csn_q[STAGES-2:0], csn_i};
      si_q  <= {si_q[STAGES-2:0], si_i};
      sck_d <= sck_q[STAGES-1];
    end
  end

  assign sck_rise_o = sck_q[STAGES-1] & ~sck_d;
  assign sck_fall_o = ~sck_q[STAGES-1] & sck_d;
  assign cs_act_o   = ~csn_q[STAGES-1];
  assign si_o       = si_q[STAGES-1];
endmodule

// File: rtl/spi_opreg_frame.sv
module spi_opreg_frame #(
  parameter int W     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_act_i,
  input  logic             sck_rise_i,
  input  logic             si_i,
  output logic             byte_done_o,
  output logic [W-1:0]     byte_o,
  output logic [IDX_W-1:0] byte_idx_o
);
  localparam int CNT_W = $clog2(W);

  logic [CNT_W-1:0] bit_q;
  logic [W-2:0]     sh_q;
  logic [IDX_W-1:0] idx_q;
  logic             last;

  assign last        = (bit_q == CNT_W'(W - 1));
  assign byte_o      = {sh_q, si_i};
  assign byte_done_o = cs_act_i & sck_rise_i & last;
  assign byte_idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      sh_q  <= '0;
      idx_q <= '0;
    end else if (!cs_act_i) begin
      bit_q <= '0;   // partial byte dropped
      idx_q <= '0;
    end else if (sck_rise_i) begin
      sh_q  <= {sh_q[W-3:0], si_i};
      bit_q <= last ? '0 : bit_q + CNT_W'(1);
      if (last && idx_q != '1) idx_q <= idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/spi_opreg_regs.sv
module spi_opreg_regs
  import spi_opreg_pkg::*;
#(
  parameter int TH_W   = 6,
  parameter int PAT_W  = 4,
  parameter int BANKS  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  tgt_e             tgt_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TH_W-1:0]  data_i,
  output logic             srst_o,
  output logic             test_o,
  output logic [BANKS-1:0] bank_o,
  output logic [PAT_W-1:0] tpat_o,
  output logic [TH_W-1:0]  g_hys_o,
  output logic [TH_W-1:0]  g_ctr_o,
  output logic [TH_W-1:0]  s_hys_o,
  output logic [TH_W-1:0]  s_ctr_o
);
  logic first;
  assign first = (idx_i == IDX_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_o <= 1'b0;
      test_o <= 1'b0;
    end else if (wr_i && tgt_i == T_CTRL) begin
      srst_o <= data_i[1];
      test_o <= data_i[0] & ~data_i[1];
    end else if (srst_o) begin
      test_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o  <= '0;
      tpat_o  <= '0;
      g_hys_o <= '0;
      g_ctr_o <= '0;
      s_hys_o <= '0;
      s_ctr_o <= '0;
    end else if (srst_o) begin
      bank_o  <= '0;
      tpat_o  <= '0;
      g_hys_o <= '0;
      g_ctr_o <= '0;
      s_hys_o <= '0;
      s_ctr_o <= '0;
    end else if (wr_i) begin
      case (tgt_i)
        T_BANK: bank_o <= data_i[BANKS-1:0];
        T_TPAT: tpat_o <= data_i[PAT_W-1:0];
        T_GTH:  if (first) g_hys_o <= data_i; else g_ctr_o <= data_i;
        T_STH:  if (first) s_hys_o <= data_i; else s_ctr_o <= data_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_opreg_tx.sv
module spi_opreg_tx #(
  parameter int W     = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_act_i,
  input  logic             sck_fall_i,
  input  logic             load_i,
  input  logic [W-1:0]     word_i,
  input  logic [CNT_W-1:0] nbits_i,
  output logic             so_o,
  output logic             so_oe_o
);
  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      rem_q   <= '0;
      so_o    <= 1'b0;
      so_oe_o <= 1'b0;
    end else if (!cs_act_i) begin
      rem_q   <= '0;
      so_o    <= 1'b0;
      so_oe_o <= 1'b0;
    end else if (load_i) begin
      sh_q  <= word_i;
      rem_q <= nbits_i;
    end else if (sck_fall_i) begin
      if (rem_q != '0) begin
        so_oe_o <= 1'b1;
        so_o    <= sh_q[W-1];
        sh_q    <= {sh_q[W-2:0], 1'b0};
        rem_q   <= rem_q - CNT_W'(1);
      end else begin
        so_oe_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_opreg_slave.sv
module spi_opreg_slave
  import spi_opreg_pkg::*;
#(
  parameter int TH_W        = 6,
  parameter int PAT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sck_i,
  input  logic                        csn_i,
  input  logic                        si_i,
  input  logic [N_BANKS*BYTE_W-1:0]   status_i,
  output logic                        so_o,
  output logic                        so_oe_o,
  output logic                        soft_rst_o,
  output logic                        test_en_o,
  output logic [N_BANKS-1:0]          bank_type_o,
  output logic [PAT_W-1:0]            test_pat_o,
  output logic [TH_W-1:0]             gnd_hys_o,
  output logic [TH_W-1:0]             gnd_ctr_o,
  output logic [TH_W-1:0]             sup_hys_o,
  output logic [TH_W-1:0]             sup_ctr_o
);
  localparam int STAT_W = N_BANKS * BYTE_W;
  localparam int CNT_W  = $clog2(STAT_W + 1);

  logic              sck_rise, sck_fall, cs_act, si_s;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic [IDX_W-1:0]  byte_idx;

  spi_opreg_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .sck_i, .csn_i, .si_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .cs_act_o(cs_act), .si_o(si_s)
  );

  spi_opreg_frame #(.W(BYTE_W), .IDX_W(IDX_W)) i_frame (
    .clk_i, .rst_ni, .cs_act_i(cs_act), .sck_rise_i(sck_rise), .si_i(si_s),
    .byte_done_o(byte_done), .byte_o(byte_val), .byte_idx_o(byte_idx)
  );

  // Opcode held for the rest of the frame
  op_t             op_new;
  logic            op_rd_q;
  tgt_e            op_tgt_q;
  logic [NB_W-1:0] op_nb_q;
  logic            opc_done;

  assign op_new   = op_decode(byte_val);
  assign opc_done = byte_done && (byte_idx == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_rd_q  <= 1'b0;
      op_tgt_q <= T_NONE;
      op_nb_q  <= '0;
    end else if (!cs_act) begin
      op_rd_q  <= 1'b0;
      op_tgt_q <= T_NONE;
      op_nb_q  <= '0;
    end else if (opc_done) begin
      op_rd_q  <= op_new.rd;
      op_tgt_q <= op_new.tgt;
      op_nb_q  <= op_new.nbytes;
    end
  end

  logic wr;
  assign wr = byte_done && !op_rd_q && (byte_idx != '0) &&
              (NB_W'(byte_idx) <= op_nb_q) && (op_tgt_q != T_NONE);

  spi_opreg_regs #(.TH_W(TH_W), .PAT_W(PAT_W), .BANKS(N_BANKS)) i_regs (
    .clk_i, .rst_ni, .wr_i(wr), .tgt_i(op_tgt_q), .idx_i(byte_idx),
    .data_i(byte_val[TH_W-1:0]),
    .srst_o(soft_rst_o), .test_o(test_en_o), .bank_o(bank_type_o), .tpat_o(test_pat_o),
    .g_hys_o(gnd_hys_o), .g_ctr_o(gnd_ctr_o), .s_hys_o(sup_hys_o), .s_ctr_o(sup_ctr_o)
  );

  // Read word, left-aligned; this load is the status snapshot
  logic [BYTE_W-1:0] rb0, rb1;
  logic [STAT_W-1:0] rd_word;
  logic [CNT_W-1:0]  rd_bits;
  logic              load;

  always_comb begin
    rb0 = '0;
    rb1 = '0;
    case (op_new.tgt)
      T_CTRL: rb0 = BYTE_W'({soft_rst_o, test_en_o});
      T_BANK: rb0 = BYTE_W'(bank_type_o);
      T_TPAT: rb0 = BYTE_W'(test_pat_o);
      T_GTH:  begin rb0 = BYTE_W'(gnd_hys_o); rb1 = BYTE_W'(gnd_ctr_o); end
      T_STH:  begin rb0 = BYTE_W'(sup_hys_o); rb1 = BYTE_W'(sup_ctr_o); end
      T_STAT: rb0 = status_i[op_new.sel*BYTE_W +: BYTE_W];
      default: ;
    endcase
    if (op_new.tgt == T_ALL) rd_word = status_i;
    else                     rd_word = {rb0, rb1, {(STAT_W-2*BYTE_W){1'b0}}};
  end

  assign rd_bits = CNT_W'(int'(op_new.nbytes) * BYTE_W);
  assign load    = opc_done && op_new.rd;

  spi_opreg_tx #(.W(STAT_W), .CNT_W(CNT_W)) i_tx (
    .clk_i, .rst_ni, .cs_act_i(cs_act), .sck_fall_i(sck_fall), .load_i(load),
    .word_i(rd_word), .nbits_i(rd_bits), .so_o, .so_oe_o
  );
endmodule

// File: rtl/spi_opreg_chk.sv
module spi_opreg_chk #(
  parameter int TH_W  = 6,
  parameter int PAT_W = 4,
  parameter int BANKS = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_act_i,
  input logic             sck_fall_i,
  input logic             byte_done_i,
  input logic             so_o,
  input logic             so_oe_o,
  input logic             soft_rst_o,
  input logic             test_en_o,
  input logic [BANKS-1:0] bank_type_o,
  input logic [PAT_W-1:0] test_pat_o,
  input logic [TH_W-1:0]  gnd_hys_o,
  input logic [TH_W-1:0]  gnd_ctr_o,
  input logic [TH_W-1:0]  sup_hys_o,
  input logic [TH_W-1:0]  sup_ctr_o
);
  p_oe_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !so_oe_o);

  p_oe_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(so_oe_o) |-> $past(sck_fall_i));

  p_so_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (so_oe_o && $past(so_oe_o) && !$past(sck_fall_i)) |-> $stable(so_o));

  p_srst_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_o && $past(soft_rst_o)) |->
      (!test_en_o && bank_type_o == '0 && test_pat_o == '0 &&
       gnd_hys_o == '0 && gnd_ctr_o == '0 && sup_hys_o == '0 && sup_ctr_o == '0));

  p_bank_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank_type_o) |-> ($past(byte_done_i) || $past(soft_rst_o)));
endmodule

bind spi_opreg_slave spi_opreg_chk #(.TH_W(TH_W), .PAT_W(PAT_W), .BANKS(spi_opreg_pkg::N_BANKS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_act_i(cs_act), .sck_fall_i(sck_fall),
  .byte_done_i(byte_done), .so_o(so_o), .so_oe_o(so_oe_o), .soft_rst_o(soft_rst_o),
  .test_en_o(test_en_o), .bank_type_o(bank_type_o), .test_pat_o(test_pat_o),
  .gnd_hys_o(gnd_hys_o), .gnd_ctr_o(gnd_ctr_o), .sup_hys_o(sup_hys_o), .sup_ctr_o(sup_ctr_o)
);

// File: tb/test_spi_opreg_slave.sv
module test_spi_opreg_slave;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, sck, csn, si;
  logic [31:0] status;
  logic        so, so_oe, srst, test_en;
  logic [3:0]  bank, tpat;
  logic [5:0]  ghys, gctr, shys, sctr;

  spi_opreg_slave i_spi_opreg_slave (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .si_i(si), .status_i(status),
    .so_o(so), .so_oe_o(so_oe), .soft_rst_o(srst), .test_en_o(test_en),
    .bank_type_o(bank), .test_pat_o(tpat), .gnd_hys_o(ghys), .gnd_ctr_o(gctr),
    .sup_hys_o(shys), .sup_ctr_o(sctr)
  );

  int          errors = 0, checks = 0;
  logic [7:0]  exp_q[$];
  int          rd_bytes = 0, bit_n = 0, sw_bit = -1;
  logic [31:0] sw_val = '0;
  logic [7:0]  acc = '0;
  string       cur_req = "";

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Monitor: collects SO bits at each SCK rise and scores them
  always @(negedge csn) bit_n = 0;
  always @(posedge sck) if (!csn) begin
    if (bit_n >= 8 && bit_n < 8 + 8*rd_bytes) begin
      chk({cur_req, " so enabled"}, 32'(so_oe), 32'd1);
      acc = {acc[6:0], so};
      if ((bit_n - 8) % 8 == 7) begin
        if (exp_q.size() == 0) chk({cur_req, " unexpected byte"}, 32'(acc), 32'hxx);
        else chk(cur_req, 32'(acc), 32'(exp_q.pop_front()));
      end
    end else begin
      chk("R11 so high-Z", 32'(so_oe), 32'd0);
    end
    bit_n++;
  end

  task automatic spi_frame(input logic [39:0] bits, input int nbits);
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i == sw_bit) status = sw_val;
      si = bits[39-i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    si  = 1'b0;
    repeat (3*HALF) @(negedge clk);
  endtask

  task automatic wr1(input logic [7:0] op, input logic [7:0] d);
    spi_frame({op, d, 24'h0}, 16);
  endtask

  task automatic wr2(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b);
    spi_frame({op, a, b, 16'h0}, 24);
  endtask

  // Driver: pushes expected bytes, then clocks the frame
  task automatic rd(input string req, input logic [7:0] op, input int n, input int nclk,
                    input logic [31:0] exp, input logic [31:0] junk);
    for (int k = 0; k < n; k++) exp_q.push_back(exp[31-8*k -: 8]);
    cur_req  = req;
    rd_bytes = n;
    spi_frame({op, junk}, 8 + 8*nclk);
    rd_bytes = 0;
    chk({req, " all bytes seen"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  task automatic chk_regs(input string req, input logic s, input logic t, input logic [3:0] b,
                          input logic [3:0] p, input logic [5:0] gh, input logic [5:0] gc,
                          input logic [5:0] sh, input logic [5:0] sc);
    chk({req, " soft_rst"}, 32'(srst), 32'(s));
    chk({req, " test_en"},  32'(test_en), 32'(t));
    chk({req, " bank"},     32'(bank), 32'(b));
    chk({req, " pattern"},  32'(tpat), 32'(p));
    chk({req, " gnd_hys"},  32'(ghys), 32'(gh));
    chk({req, " gnd_ctr"},  32'(gctr), 32'(gc));
    chk({req, " sup_hys"},  32'(shys), 32'(sh));
    chk({req, " sup_ctr"},  32'(sctr), 32'(sc));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sck = 1'b0; csn = 1'b1; si = 1'b0; status = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 so_oe", 32'(so_oe), 32'd0);
    chk_regs("R1", 0, 0, 4'h0, 4'h0, 6'h00, 6'h00, 6'h00, 6'h00);
    rd("R1 R4 ctrl after reset", 8'h82, 1, 1, 32'h00000000, 32'h0);

    // R2: single-byte writes, upper bits dropped
    wr1(8'h02, 8'h01);
    wr1(8'h04, 8'h0A);
    wr1(8'h1E, 8'hF5);
    chk_regs("R2", 0, 1, 4'hA, 4'h5, 6'h00, 6'h00, 6'h00, 6'h00);

    // R3: hysteresis byte first, center second
    wr2(8'h3A, 8'hC6, 8'h4F);
    wr2(8'h3C, 8'h06, 8'h12);
    chk_regs("R3", 0, 1, 4'hA, 4'h5, 6'h06, 6'h0F, 6'h06, 6'h12);

    // R4 readback; R12 with SI held high during data
    rd("R4 ctrl",    8'h82, 1, 1, 32'h01000000, 32'hFFFFFFFF);
    rd("R4 bank",    8'h84, 1, 1, 32'h0A000000, 32'hFFFFFFFF);
    rd("R4 pattern", 8'h9E, 1, 1, 32'h05000000, 32'hFFFFFFFF);
    rd("R4 gnd pair", 8'hBA, 2, 2, 32'h060F0000, 32'hFFFFFFFF);
    rd("R4 sup pair", 8'hBC, 2, 2, 32'h06120000, 32'hFFFFFFFF);
    chk_regs("R12", 0, 1, 4'hA, 4'h5, 6'h06, 6'h0F, 6'h06, 6'h12);

    // R5: per-bank status
    status = 32'hA1B2C3D4;
    rd("R5 bank0", 8'h90, 1, 1, 32'hD4000000, 32'h0);
    rd("R5 bank1", 8'h92, 1, 1, 32'hC3000000, 32'h0);
    rd("R5 bank2", 8'h94, 1, 1, 32'hB2000000, 32'h0);
    rd("R5 bank3", 8'h96, 1, 1, 32'hA1000000, 32'h0);

    // R6: all banks, status changes mid-read
    sw_bit = 12; sw_val = 32'h11223344;
    rd("R6 snapshot", 8'hF8, 4, 4, 32'hA1B2C3D4, 32'h0);
    sw_bit = -1;
    rd("R6 fresh", 8'hF8, 4, 4, 32'h11223344, 32'h0);

    // R7: partial data byte and partial opcode
    spi_frame({8'h04, 8'h03, 24'h0}, 13);
    chk("R7 partial data byte", 32'(bank), 32'hA);
    spi_frame({8'h04, 32'h0}, 5);
    wr1(8'h04, 8'h0C);
    chk("R7 fresh opcode after partial", 32'(bank), 32'hC);

    // R8: extra bytes ignored
    spi_frame({8'h04, 8'h05, 8'h02, 8'h03, 8'h00}, 40);
    chk_regs("R8 extra write bytes", 0, 1, 4'h5, 4'h5, 6'h06, 6'h0F, 6'h06, 6'h12);
    rd("R8 extra read bytes", 8'h84, 1, 3, 32'h05000000, 32'h0);

    // R10: reserved opcodes
    wr1(8'h06, 8'hFF);
    wr1(8'h10, 8'hFF);
    chk_regs("R10 reserved write", 0, 1, 4'h5, 4'h5, 6'h06, 6'h0F, 6'h06, 6'h12);
    rd("R10 reserved read 0x80", 8'h80, 1, 1, 32'h0, 32'h0);
    rd("R10 reserved read 0xA0", 8'hA0, 1, 1, 32'h0, 32'h0);

    // R9: soft reset hold and release
    wr1(8'h02, 8'h02);
    chk_regs("R9 hold", 1, 0, 4'h0, 4'h0, 6'h00, 6'h00, 6'h00, 6'h00);
    wr1(8'h04, 8'h0F);
    wr2(8'h3A, 8'h07, 8'h09);
    chk_regs("R9 write blocked", 1, 0, 4'h0, 4'h0, 6'h00, 6'h00, 6'h00, 6'h00);
    rd("R9 ctrl readback", 8'h82, 1, 1, 32'h02000000, 32'h0);
    wr1(8'h02, 8'h00);
    wr1(8'h04, 8'h03);
    chk_regs("R9 release", 0, 0, 4'h3, 4'h0, 6'h00, 6'h00, 6'h00, 6'h00);

    // R11: idle with CSN high
    repeat (10) @(negedge clk);
    chk("R11 idle", 32'(so_oe), 32'd0);

    finish_run();
  end
endmodule